// File: doc/BRIEF.md
# Sinc5 and Averaging Decimation Filter

This block turns the one-sample-per-strobe bitstream of an oversampling modulator into a slower stream of wide result words. The main path is a fifth-order sinc filter. It is built from integrators that run at the sample rate, a sample switch that keeps one value in every 32, and differentiators that run at the decimated rate. A second stage can average a power-of-two number of consecutive sinc results. This lowers the output rate further and reduces noise. A mode input switches the main path to a third-order sinc filter at the same decimation.

Each new result word is announced by a one-cycle data-ready pulse. After reset, the block discards the decimated results that have not yet settled and waits one further period before it publishes anything. It does the same after any change of mode or averaging count, because such a change flushes all filter state. Both filter orders are scaled to the same full scale, so downstream logic does not need to know which mode is active.

Top module: `sincavg_decimator`

## Requirements
- R1: While rst_n is low, and after its release until the first output, drdy is 0 and result is 0.
- R2: With mode=0 the block computes one decimated value per 32 accepted samples. That value is the accepted input sequence convolved with the coefficients of (1+z^-1+...+z^-31)^5, so a steady input of +1 yields 2^25.
- R3: With mode=1 the filter is third order with the same decimation by 32. Its decimated value is multiplied by 2^10, so a steady +1 again yields 2^25.
- R4: The sample is a 2-bit two's complement code (-2..+1) and is taken only in cycles where sample_stb is 1. Its value in any other cycle has no effect on any result.
- R5: avg_code k (0, 1, 2, 3) selects N = 2^k. Each output is the sum of N consecutive published sinc results, arithmetically shifted right by k (rounded toward minus infinity).
- R6: After reset or a flush, the first P decimated values are discarded, where P is 5 in mode 0 and 3 in mode 1. The first drdy therefore follows exactly 32*(P+N) accepted samples.
- R7: After the first output, each further output follows another 32*N accepted samples.
- R8: drdy is high for exactly one clock cycle, together with the new result. It rises on the third rising edge when the edge that accepts the completing sample is counted as the first.
- R9: Any change of mode or avg_code clears all filter state at the next rising edge. The latency of R6 then restarts, and no sample accepted before the change affects a later output.
- R10: A steady input of -2 yields exactly -2^26 and a steady +1 yields exactly 2^25 in both modes, at every averaging count, without wraparound.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sample_stb | input | 1 | Sample strobe; the sample is taken when it is high |
| sample_i | input | IN_W (2) | Two's complement modulator code |
| mode_i | input | 1 | 0 selects the fifth-order path, 1 the third-order path |
| avg_code_i | input | AVG_CW (2) | log2 of the averaging count |
| result_o | output | OUT_W (27) | Signed result word |
| drdy_o | output | 1 | One-cycle pulse when result_o is new |

## Verification
The one-cycle data-ready assertion takes for granted that there is at most one strobe per clock cycle, which makes decimation events at least 32 cycles apart. The flush assertion takes for granted that a configuration change does not come in the same cycle as a strobe. The bench keeps within both: it spaces strobes five cycles apart, and it changes mode or averaging count only while the strobe is low, then leaves idle cycles before streaming again. The overflow bound holds for every 2-bit code, so the stimulus uses the whole code range, including steady runs of the most negative code.

// File: rtl/sincavg_pkg.sv
package sincavg_pkg;

   // Selects which filter order forms the main path.
   typedef enum logic {
      FILT_HI = 1'b0,
      FILT_LO = 1'b1
   } filt_sel_e;

   // Width that a cascade of `ord` integrators needs for modulo arithmetic.
   function automatic int cic_width(input int in_w, input int ord, input int dec_log);
      return in_w + ord * dec_log;
   endfunction

endpackage

// File: rtl/sincavg_integ.sv
module sincavg_integ #(
   parameter int IN_W    = 2,
   parameter int ACC_W   = 27,
   parameter int ORD     = 5,
   parameter int ORD_LO  = 3,
   parameter int DEC_LOG = 5
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    flush,
   input  logic                    stb,
   input  logic [IN_W-1:0]         sample,
   input  logic                    sel_lo,
   output logic                    dec_vld_o,
   output logic signed [ACC_W-1:0] dec_smp_o
);

   localparam logic [DEC_LOG-1:0] PH_LAST = {DEC_LOG{1'b1}};

   logic signed [ACC_W-1:0] acc_q [ORD];
   logic signed [ACC_W-1:0] acc_d [ORD];
   logic signed [ACC_W-1:0] smp_ext;
   logic [DEC_LOG-1:0]      phase_q;
   logic                    take;
   logic                    boundary;

   assign smp_ext  = ACC_W'($signed(sample));
   assign take     = stb && !flush;
   assign boundary = take && (phase_q == PH_LAST);

   // Whole cascade settles within one cycle so every stage sees the same sample.
   for (genvar g = 0; g < ORD; g++) begin : g_stage
      if (g == 0) begin : g_first
         assign acc_d[g] = acc_q[g] + smp_ext;
      end else begin : g_next
         assign acc_d[g] = acc_q[g] + acc_d[g-1];
      end

      always_ff @(posedge clk) begin
         if (!rst_n || flush) begin
            acc_q[g] <= '0;
         end else if (take) begin
            acc_q[g] <= acc_d[g];
         end
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n || flush) begin
         phase_q   <= '0;
         dec_vld_o <= 1'b0;
         dec_smp_o <= '0;
      end else begin
         dec_vld_o <= boundary;
         if (take) begin
            phase_q <= phase_q + 1'b1;
         end
         if (boundary) begin
            dec_smp_o <= sel_lo ? acc_d[ORD_LO-1] : acc_d[ORD-1];
         end
      end
   end

   // R4: a decimated value only ever follows an accepted strobe
   p_dec_after_stb_r4: assert property (@(posedge clk) disable iff (!rst_n)
      dec_vld_o |-> $past(stb && !flush));

endmodule

// File: rtl/sincavg_comb.sv
module sincavg_comb #(
   parameter int IN_W    = 2,
   parameter int ACC_W   = 27,
   parameter int ORD     = 5,
   parameter int ORD_LO  = 3,
   parameter int DEC_LOG = 5
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    flush,
   input  logic                    in_vld,
   input  logic signed [ACC_W-1:0] in_smp,
   input  logic                    sel_lo,
   output logic                    res_vld_o,
   output logic signed [ACC_W-1:0] res_o
);

   localparam int CNT_W   = $clog2(ORD + 1);
   localparam int LO_SHL  = (ORD - ORD_LO) * DEC_LOG;
   localparam logic [CNT_W-1:0] SETTLE_HI = CNT_W'(ORD);
   localparam logic [CNT_W-1:0] SETTLE_LO = CNT_W'(ORD_LO);
   localparam longint RES_MAX = ((longint'(1) << (IN_W - 1)) - 1) << (ORD * DEC_LOG);
   localparam longint RES_MIN = -(longint'(1) << (IN_W - 1 + ORD * DEC_LOG));

   logic signed [ACC_W-1:0] diff  [ORD+1];
   logic signed [ACC_W-1:0] dly_q [ORD];
   logic signed [ACC_W-1:0] picked;
   logic [CNT_W-1:0]        seen_q;
   logic [CNT_W-1:0]        settle;

   assign diff[0] = in_smp;

   for (genvar g = 0; g < ORD; g++) begin : g_diff
      assign diff[g+1] = diff[g] - dly_q[g];

      always_ff @(posedge clk) begin
         if (!rst_n || flush) begin
            dly_q[g] <= '0;
         end else if (in_vld) begin
            dly_q[g] <= diff[g];
         end
      end
   end

   // Bring the lower order up to the same full scale as the main path.
   assign picked = sel_lo ? (diff[ORD_LO] <<< LO_SHL) : diff[ORD];
   assign settle = sel_lo ? SETTLE_LO : SETTLE_HI;

   always_ff @(posedge clk) begin
      if (!rst_n || flush) begin
         seen_q    <= '0;
         res_vld_o <= 1'b0;
         res_o     <= '0;
      end else begin
         res_vld_o <= 1'b0;
         if (in_vld) begin
            if (seen_q == settle) begin
               res_vld_o <= 1'b1;
               res_o     <= picked;
            end else begin
               seen_q <= seen_q + 1'b1;
            end
         end
      end
   end

   // R10: published sinc values stay inside the input full scale
   p_no_overflow_r10: assert property (@(posedge clk) disable iff (!rst_n)
      res_vld_o |-> (longint'(res_o) <= RES_MAX && longint'(res_o) >= RES_MIN));

endmodule

// File: rtl/sincavg_avg.sv
module sincavg_avg #(
   parameter int W       = 27,
   parameter int LOG_MAX = 3,
   parameter int CW      = 2
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                flush,
   input  logic                in_vld,
   input  logic signed [W-1:0] in_res,
   input  logic [CW-1:0]       log_n,
   output logic                out_vld_o,
   output logic signed [W-1:0] out_res_o
);

   if (LOG_MAX == 0) begin : g_pass
      always_ff @(posedge clk) begin
         if (!rst_n || flush) begin
            out_vld_o <= 1'b0;
            out_res_o <= '0;
         end else begin
            out_vld_o <= in_vld;
            if (in_vld) begin
               out_res_o <= in_res;
            end
         end
      end
   end else begin : g_box
      localparam int SUM_W = W + LOG_MAX;
      localparam int CNT_W = LOG_MAX + 1;

      logic signed [SUM_W-1:0] acc_q;
      logic signed [SUM_W-1:0] sum;
      logic [CNT_W-1:0]        cnt_q;
      logic [CNT_W-1:0]        cnt_nxt;
      logic [CNT_W-1:0]        target;

      assign sum     = acc_q + SUM_W'(in_res);
      assign cnt_nxt = cnt_q + 1'b1;
      assign target  = CNT_W'(1) << log_n;

      always_ff @(posedge clk) begin
         if (!rst_n || flush) begin
            acc_q     <= '0;
            cnt_q     <= '0;
            out_vld_o <= 1'b0;
            out_res_o <= '0;
         end else begin
            out_vld_o <= 1'b0;
            if (in_vld) begin
               if (cnt_nxt == target) begin
                  out_vld_o <= 1'b1;
                  out_res_o <= W'(sum >>> log_n);
                  acc_q     <= '0;
                  cnt_q     <= '0;
               end else begin
                  acc_q <= sum;
                  cnt_q <= cnt_nxt;
               end
            end
         end
      end
   end

   // R8: the ready pulse never lasts two cycles
   p_drdy_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
      out_vld_o |=> !out_vld_o);

   // R5: each averaged output is completed by a fresh sinc result
   p_out_after_in_r5: assert property (@(posedge clk) disable iff (!rst_n)
      out_vld_o |-> $past(in_vld && !flush));

endmodule

// File: rtl/sincavg_decimator.sv
module sincavg_decimator
   import sincavg_pkg::*;
#(
   parameter int IN_W        = 2,
   parameter int DEC_LOG     = 5,
   parameter int ORD_HI      = 5,
   parameter int ORD_LO      = 3,
   parameter int AVG_LOG_MAX = 3,
   parameter int AVG_CW      = $clog2(AVG_LOG_MAX + 1),
   parameter int OUT_W       = IN_W + ORD_HI * DEC_LOG
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              sample_stb,
   input  logic [IN_W-1:0]   sample_i,
   input  logic              mode_i,
   input  logic [AVG_CW-1:0] avg_code_i,
   output logic [OUT_W-1:0]  result_o,
   output logic              drdy_o
);

   localparam int ACC_W = cic_width(IN_W, ORD_HI, DEC_LOG);

   initial begin
      assert (IN_W >= 1) else $error("IN_W must be at least 1");
      assert (ORD_LO >= 1 && ORD_LO < ORD_HI) else $error("ORD_LO must lie in 1..ORD_HI-1");
      assert (AVG_LOG_MAX >= 1) else $error("AVG_LOG_MAX must be at least 1");
      assert (OUT_W == ACC_W) else $error("OUT_W must equal the integrator width");
      assert (ACC_W <= 62) else $error("integrator width too large");
      assert ((1 << AVG_CW) > AVG_LOG_MAX) else $error("AVG_CW too narrow");
   end

   filt_sel_e               sel_q;
   logic [AVG_CW-1:0]       avg_q;
   logic [AVG_CW-1:0]       avg_eff;
   logic                    flush;
   logic                    sel_lo;
   logic                    dec_vld;
   logic signed [ACC_W-1:0] dec_smp;
   logic                    res_vld;
   logic signed [ACC_W-1:0] res;
   logic signed [ACC_W-1:0] avg_res;

   assign flush  = (filt_sel_e'(mode_i) != sel_q) || (avg_code_i != avg_q);
   assign sel_lo = (sel_q == FILT_LO);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         sel_q <= FILT_HI;
         avg_q <= '0;
      end else begin
         sel_q <= filt_sel_e'(mode_i);
         avg_q <= avg_code_i;
      end
   end

   // Codes beyond the supported maximum fall back to the largest count.
   if ((1 << AVG_CW) - 1 > AVG_LOG_MAX) begin : g_clamp
      assign avg_eff = (avg_q > AVG_CW'(AVG_LOG_MAX)) ? AVG_CW'(AVG_LOG_MAX) : avg_q;
   end else begin : g_full
      assign avg_eff = avg_q;
   end

   sincavg_integ #(
      .IN_W    (IN_W),
      .ACC_W   (ACC_W),
      .ORD     (ORD_HI),
      .ORD_LO  (ORD_LO),
      .DEC_LOG (DEC_LOG)
   ) i_integ (
      .clk       (clk),
      .rst_n     (rst_n),
      .flush     (flush),
      .stb       (sample_stb),
      .sample    (sample_i),
      .sel_lo    (sel_lo),
      .dec_vld_o (dec_vld),
      .dec_smp_o (dec_smp)
   );

   sincavg_comb #(
      .IN_W    (IN_W),
      .ACC_W   (ACC_W),
      .ORD     (ORD_HI),
      .ORD_LO  (ORD_LO),
      .DEC_LOG (DEC_LOG)
   ) i_comb (
      .clk       (clk),
      .rst_n     (rst_n),
      .flush     (flush),
      .in_vld    (dec_vld),
      .in_smp    (dec_smp),
      .sel_lo    (sel_lo),
      .res_vld_o (res_vld),
      .res_o     (res)
   );

   sincavg_avg #(
      .W       (ACC_W),
      .LOG_MAX (AVG_LOG_MAX),
      .CW      (AVG_CW)
   ) i_avg (
      .clk       (clk),
      .rst_n     (rst_n),
      .flush     (flush),
      .in_vld    (res_vld),
      .in_res    (res),
      .log_n     (avg_eff),
      .out_vld_o (drdy_o),
      .out_res_o (avg_res)
   );

   assign result_o = avg_res;

   // R9: a configuration change leaves no ready pulse behind it
   p_flush_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
      flush |=> !drdy_o);

endmodule

// File: tb/test_sincavg_decimator.sv
module test_sincavg_decimator;

   localparam int NVEC = 10;
   // columns: mode, avg_code, pattern, outputs
   localparam int VEC [NVEC][4] = '{
      '{0, 0, 0, 3},
      '{0, 0, 1, 3},
      '{1, 0, 0, 3},
      '{1, 0, 1, 3},
      '{0, 0, 3, 6},
      '{1, 0, 3, 6},
      '{0, 1, 2, 4},
      '{0, 2, 3, 3},
      '{1, 3, 4, 2},
      '{0, 3, 1, 2}
   };

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        sample_stb = 1'b0;
   logic [1:0]  sample_i = 2'b00;
   logic        mode_i = 1'b0;
   logic [1:0]  avg_code_i = 2'b00;
   logic [26:0] result_o;
   logic        drdy_o;

   always #5 clk = ~clk;

   sincavg_decimator i_sincavg_decimator (
      .clk        (clk),
      .rst_n      (rst_n),
      .sample_stb (sample_stb),
      .sample_i   (sample_i),
      .mode_i     (mode_i),
      .avg_code_i (avg_code_i),
      .result_o   (result_o),
      .drdy_o     (drdy_o)
   );

   int     checks = 0;
   int     fails = 0;
   int     x_hist [1024];
   int     nsamp = 0;
   longint wts [2][160];
   longint got_val [64];
   int     got_at [64];
   int     ngot = 0;
   logic   drdy_prev = 1'b0;

   // Monitor: one-cycle ready pulse (R8) and capture of each new word.
   always @(negedge clk) begin
      if (drdy_o) begin
         checks++;
         if (drdy_prev) begin
            fails++;
            $display("FAIL R8 drdy width: actual=2+ cycles expected=1");
         end
         if (ngot < 64) begin
            got_val[ngot] = longint'($signed(result_o));
            got_at[ngot]  = nsamp;
         end
         ngot++;
      end
      drdy_prev = drdy_o;
   end

   function automatic void build_wts();
      longint tmp [160];
      for (int s = 0; s < 2; s++) begin
         int ord = (s == 0) ? 5 : 3;
         int len = 1;
         for (int j = 0; j < 160; j++) wts[s][j] = 0;
         wts[s][0] = 1;
         for (int o = 0; o < ord; o++) begin
            for (int j = 0; j < len + 31; j++) begin
               longint a = 0;
               for (int i = 0; i < 32; i++)
                  if (j - i >= 0 && j - i < len) a += wts[s][j-i];
               tmp[j] = a;
            end
            len += 31;
            for (int j = 0; j < len; j++) wts[s][j] = tmp[j];
         end
      end
   endfunction

   function automatic int pat_val(int pat, int i);
      case (pat)
         0: return 1;
         1: return -2;
         2: return ((i / 7) % 4) - 2;
         3: return ((i * 13 + (i >> 3) * 5 + (i >> 5)) % 4) - 2;
         default: return ((i / 40) % 2 == 1) ? 1 : -1;
      endcase
   endfunction

   // Decimated sinc value number k (1-based) counted from the last flush.
   function automatic longint sinc_res(int k, int sel);
      int     ord = (sel == 1) ? 3 : 5;
      longint y = 0;
      for (int j = 0; j <= 31 * ord; j++) begin
         int idx = 32 * k - 1 - j;
         if (idx >= 0) y += wts[sel][j] * longint'(x_hist[idx]);
      end
      if (sel == 1) y = y * 1024;
      return y;
   endfunction

   function automatic longint exp_out(int q, int sel, int code);
      int     n = 1 << code;
      int     ord = (sel == 1) ? 3 : 5;
      longint s = 0;
      for (int e = 0; e < n; e++) s += sinc_res(ord + 1 + q * n + e, sel);
      return s >>> code;
   endfunction

   task automatic check(input bit ok, input string tag, input longint act, input longint exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   // One accepted sample; junk is driven on the pin in the idle cycles (R4).
   task automatic drive_sample(input int v);
      @(negedge clk);
      sample_i   = 2'(v);
      sample_stb = 1'b1;
      x_hist[nsamp] = v;
      nsamp++;
      @(negedge clk);
      sample_stb = 1'b0;
      sample_i   = 2'(nsamp * 3 + 1);
      repeat (3) @(negedge clk);
   endtask

   task automatic run_case(input int mode, input int code, input int pat, input int nout,
                           input bit do_rst, input int idle, input string extra);
      int    ord = (mode == 1) ? 3 : 5;
      int    n = 1 << code;
      int    total;
      string vtag;
      @(negedge clk);
      mode_i     = mode[0];
      avg_code_i = 2'(code);
      if (do_rst) begin
         rst_n = 1'b0;
         repeat (3) @(negedge clk);
         rst_n = 1'b1;
      end
      repeat (3) @(negedge clk);
      for (int c = 0; c < idle; c++) begin
         @(negedge clk);
         sample_i = 2'(c);
      end
      nsamp = 0;
      ngot  = 0;
      total = 32 * (ord + n * nout);
      for (int i = 0; i < total; i++) drive_sample(pat_val(pat, i));
      repeat (8) @(negedge clk);
      vtag = (code != 0) ? "R5" : ((mode == 1) ? "R3" : "R2");
      check(ngot == nout, {"R7 output count ", extra}, ngot, nout);
      for (int q = 0; q < nout && q < ngot; q++) begin
         longint e = exp_out(q, mode, code);
         check(got_at[q] == 32 * (ord + n * (q + 1)),
               {(q == 0) ? "R6 latency " : "R7 spacing ", extra}, got_at[q], 32 * (ord + n * (q + 1)));
         check(got_val[q] == e, {vtag, " value ", extra}, got_val[q], e);
      end
   endtask

   initial begin
      build_wts();
      // R1: reset state
      repeat (3) @(negedge clk);
      check(drdy_o == 1'b0 && result_o == '0, "R1 in reset", longint'(result_o), 0);
      rst_n = 1'b1;
      repeat (20) @(negedge clk);
      check(drdy_o == 1'b0 && result_o == '0, "R1 after release", longint'(result_o), 0);

      for (int v = 0; v < NVEC; v++) begin
         string ex = (VEC[v][2] <= 1) ? "R10" : "";
         run_case(VEC[v][0], VEC[v][1], VEC[v][2], VEC[v][3], 1'b1, 0, ex);
      end

      // R4: a long stretch of pin activity without strobes changes nothing
      run_case(0, 0, 3, 2, 1'b1, 300, "R4");

      // R9: flush by averaging-count change after a partial period
      run_case(0, 0, 2, 2, 1'b1, 0, "R9 pre");
      for (int i = 0; i < 45; i++) drive_sample(pat_val(0, i));
      run_case(0, 1, 3, 2, 1'b0, 0, "R9 avg");

      // R9: flush by mode change mid-stream
      for (int i = 0; i < 50; i++) drive_sample(pat_val(1, i));
      run_case(1, 1, 2, 2, 1'b0, 0, "R9 mode");

      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

   initial begin
      #1500000;
      checks++;
      fails++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

endmodule